// File: doc/BRIEF.md
# Automatic Melody Player Tone Generator

The block turns a stored tune into a square wave for a speaker, and can also act as an eight-key organ. A slow beat signal, about 4 Hz, steps an address through a fixed score of 4-bit note indices. The current index selects an 11-bit divider preset, a display code for the note and a flag for the upper octave. The pitch comes from an up-counter on the fast system clock. Each time that counter reaches all ones it reloads the preset, and a toggle stage turns those overflow pulses into the speaker wave.

A play/pause input freezes the score position and silences the output. A manual input hands the note selection to eight keys. The score address wraps after its last entry, so the tune loops. The beat input is synchronized into the system clock domain, and only its rising edge is used, as an enable.

Top module: `melody_tone_gen`

## Requirements
- R1: After reset, spk_out, note_code and note_high are all 0.
- R2: The speaker output changes only in the cycle after the divider's overflow flag is seen high. The flag is high for the one cycle that follows the counter reaching all ones, and in that cycle the counter is loaded with the preset.
- R3: For a steady note with preset P, every high phase and every low phase of spk_out lasts exactly 2048 - P system clock cycles.
- R4: The preset 2047 (note index 0) is the rest value. The overflow flag then stays high and spk_out does not change.
- R5: The note index maps to preset/code/high as follows:
  - 0: 2047/0/0
  - 1: 773/1/0
  - 2: 912/2/0
  - 3: 1036/3/0
  - 4: 1116/4/0
  - 5: 1290/5/0
  - 6: 1372/6/0
  - 7: 1410/7/0
  - 8: 1480/1/1
  - 9: 1542/2/1
  - 10: 1622/3/1
  - 11: 1668/4/1
  - 12 to 15: 139, 347, 533 and 615, with codes 1 to 4 and high 0.
  note_code and note_high show the code and flag of the selected index.
- R6: Each rising edge of beat_in taken while play is 1 advances the score address by one. The address runs over 128 entries and wraps from 127 to 0, and it changes at no other time.
- R7: The score entry at address a is as follows. Let q = a >> 2. If q mod 8 = 7 the entry is index 0. Otherwise it is index ((3*q) mod 11) + 1. Each note therefore lasts four beats.
- R8: While play is 0 and manual is 0, the address holds and the selected index is 0. note_code is 0 and the speaker is silent. On resume the tune continues from the held address.
- R9: While manual is 1, keys replace the score. Key k (bit k) selects index k+1, the lowest-numbered pressed key wins, and no pressed key selects index 0.
- R10: A beat edge that reaches the address stage in the same cycle as play = 0 is dropped, not deferred.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 12 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| beat_in | input | 1 | Beat-rate clock, asynchronous, about 4 Hz |
| play | input | 1 | 1 = play the score, 0 = pause |
| manual | input | 1 | 1 = keys select the note instead of the score |
| keys | input | 8 | Organ keys, bit k selects scale note k |
| spk_out | output | 1 | Square wave to the speaker |
| note_code | output | 4 | Display code of the sounding note |
| note_high | output | 1 | Upper-octave flag of the sounding note |

## Verification
The score advance and the pause control can act in the same cycle. This happens when a synchronized beat edge reaches the address register in the same cycle that play drops. The bench counts the two synchronizer stages and lowers play exactly in the cycle where the edge pulse is live, at an address where the next entry has a different code. A second run lowers play one cycle later. After resume, the displayed code must show the held entry in the first run and the advanced entry in the second.

// File: rtl/melody_pkg.sv
package melody_pkg;
  localparam int unsigned DIV_W  = 11;
  localparam int unsigned IDX_W  = 4;
  localparam int unsigned CODE_W = 4;

  typedef struct packed {
    logic [DIV_W-1:0]  preset;
    logic [CODE_W-1:0] code;
    logic              high;
  } note_attr_t;

  function automatic note_attr_t note_lookup(input logic [IDX_W-1:0] idx);
    note_attr_t a;
    case (idx)
      4'd1:    a = '{preset: 11'd773,  code: 4'd1, high: 1'b0};
      4'd2:    a = '{preset: 11'd912,  code: 4'd2, high: 1'b0};
      4'd3:    a = '{preset: 11'd1036, code: 4'd3, high: 1'b0};
      4'd4:    a = '{preset: 11'd1116, code: 4'd4, high: 1'b0};
      4'd5:    a = '{preset: 11'd1290, code: 4'd5, high: 1'b0};
      4'd6:    a = '{preset: 11'd1372, code: 4'd6, high: 1'b0};
      4'd7:    a = '{preset: 11'd1410, code: 4'd7, high: 1'b0};
      4'd8:    a = '{preset: 11'd1480, code: 4'd1, high: 1'b1};
      4'd9:    a = '{preset: 11'd1542, code: 4'd2, high: 1'b1};
      4'd10:   a = '{preset: 11'd1622, code: 4'd3, high: 1'b1};
      4'd11:   a = '{preset: 11'd1668, code: 4'd4, high: 1'b1};
      4'd12:   a = '{preset: 11'd139,  code: 4'd1, high: 1'b0};
      4'd13:   a = '{preset: 11'd347,  code: 4'd2, high: 1'b0};
      4'd14:   a = '{preset: 11'd533,  code: 4'd3, high: 1'b0};
      4'd15:   a = '{preset: 11'd615,  code: 4'd4, high: 1'b0};
      default: a = '{preset: 11'd2047, code: 4'd0, high: 1'b0};
    endcase
    return a;
  endfunction

  // Score contents: four beats per note, a rest every eighth note slot.
  function automatic logic [IDX_W-1:0] score_entry(input int unsigned addr);
    int unsigned q;
    q = addr >> 2;
    if ((q % 8) == 7) return '0;
    return IDX_W'(((3 * q) % 11) + 1);
  endfunction
endpackage

// File: rtl/melody_beat_edge.sv
module melody_beat_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic beat_async,
  output logic beat_rise
);
  logic [STAGES:0] chain_q;
  logic [STAGES:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-1:0], beat_async};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  // chain_q[STAGES-1] is the synchronized level; chain_q[STAGES] its delayed copy.
  assign beat_rise = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/melody_score.sv
module melody_score
  import melody_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  output logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  entry
);
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    addr_d = addr_q;
    if (step_en) addr_d = addr_q + 1'b1;   // natural wrap after last entry
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign addr  = addr_q;
  assign entry = score_entry(int'(addr_q));
endmodule

// File: rtl/melody_tone_div.sv
module melody_tone_div #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] preset,
  output logic         full,
  output logic         spk
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_d;
  logic         full_q, full_d;
  logic         fdly_q;
  logic         spk_q, spk_d;

  always_comb begin
    if (cnt_q == TOP) begin
      cnt_d  = preset;
      full_d = 1'b1;
    end else begin
      cnt_d  = cnt_q + 1'b1;
      full_d = 1'b0;
    end
    spk_d = spk_q;
    if (full_q && !fdly_q) spk_d = ~spk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
      fdly_q <= 1'b0;
      spk_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      full_q <= full_d;
      fdly_q <= full_q;
      spk_q  <= spk_d;
    end
  end

  assign full = full_q;
  assign spk  = spk_q;
endmodule

// File: rtl/melody_tone_gen.sv
module melody_tone_gen
  import melody_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int KEYS        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            beat_in,
  input  logic            play,
  input  logic            manual,
  input  logic [KEYS-1:0] keys,
  output logic            spk_out,
  output logic [CODE_W-1:0] note_code,
  output logic            note_high
);
  logic [1:0]         rst_pipe_q;
  logic               rst_ok;
  logic               beat_rise;
  logic               beat_adv;
  logic [ADDR_W-1:0]  score_addr;
  logic [IDX_W-1:0]   score_idx;
  logic [IDX_W-1:0]   key_idx;
  logic [IDX_W-1:0]   sel_d, sel_q;
  note_attr_t         attr;
  logic               div_full;

  // Reset: asserted at once, released after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ok = rst_pipe_q[1];

  melody_beat_edge #(.STAGES(SYNC_STAGES)) u_beat (
    .clk(clk), .rst_n(rst_ok), .beat_async(beat_in), .beat_rise(beat_rise)
  );

  assign beat_adv = beat_rise & play;

  melody_score #(.ADDR_W(ADDR_W)) u_score (
    .clk(clk), .rst_n(rst_ok), .step_en(beat_adv),
    .addr(score_addr), .entry(score_idx)
  );

  // Lowest-numbered pressed key wins.
  always_comb begin
    key_idx = '0;
    for (int k = KEYS - 1; k >= 0; k--) begin
      if (keys[k]) key_idx = IDX_W'(k + 1);
    end
  end

  always_comb begin
    if (manual)    sel_d = key_idx;
    else if (play) sel_d = score_idx;
    else           sel_d = '0;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) sel_q <= '0;
    else         sel_q <= sel_d;
  end

  assign attr = note_lookup(sel_q);

  melody_tone_div #(.W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_ok), .preset(attr.preset),
    .full(div_full), .spk(spk_out)
  );

  assign note_code = attr.code;
  assign note_high = attr.high;
endmodule

// File: rtl/melody_tone_gen_chk.sv
module melody_tone_gen_chk #(
  parameter int ADDR_W = 7,
  parameter int KEYS   = 8
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              play,
  input logic              manual,
  input logic [KEYS-1:0]   keys,
  input logic [ADDR_W-1:0] score_addr,
  input logic              beat_adv,
  input logic              div_full,
  input logic              spk_out,
  input logic [3:0]        note_code
);
  // R2: speaker moves only after the overflow flag
  a_r2_toggle_on_full: assert property (@(posedge clk) disable iff (!rst_ok)
    (spk_out != $past(spk_out)) |-> $past(div_full));

  // R4: a flag held high (rest) never toggles the speaker
  a_r4_rest_quiet: assert property (@(posedge clk) disable iff (!rst_ok)
    (div_full && $past(div_full)) |=> $stable(spk_out));

  // R6: address steps by exactly one
  a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_ok)
    (score_addr != $past(score_addr)) |-> (score_addr == $past(score_addr) + 1'b1));

  // R6: no step without a taken beat edge
  a_r6_addr_hold: assert property (@(posedge clk) disable iff (!rst_ok)
    !beat_adv |=> $stable(score_addr));

  // R8: pause forces the rest code
  a_r8_pause_rest: assert property (@(posedge clk) disable iff (!rst_ok)
    (!play && !manual) |=> (note_code == 4'd0));

  // R9: manual with no key selects rest
  a_r9_no_key_rest: assert property (@(posedge clk) disable iff (!rst_ok)
    (manual && keys == '0) |=> (note_code == 4'd0));
endmodule

bind melody_tone_gen melody_tone_gen_chk #(.ADDR_W(ADDR_W), .KEYS(KEYS)) u_chk (
  .clk(clk), .rst_ok(rst_ok), .play(play), .manual(manual), .keys(keys),
  .score_addr(score_addr), .beat_adv(beat_adv), .div_full(div_full),
  .spk_out(spk_out), .note_code(note_code)
);

// File: tb/melody_tone_gen_test.sv
module melody_tone_gen_test;
  logic clk = 1'b0;
  logic rst_n, beat_in, play, manual;
  logic [7:0] keys;
  logic spk_out, note_high;
  logic [3:0] note_code;
  int total = 0;
  int bad = 0;
  int beats_taken = 0;

  always #2 clk = ~clk;

  melody_tone_gen uut (
    .clk(clk), .rst_n(rst_n), .beat_in(beat_in), .play(play), .manual(manual),
    .keys(keys), .spk_out(spk_out), .note_code(note_code), .note_high(note_high)
  );

  function automatic int exp_preset(input int i);
    case (i)
      1: return 773;  2: return 912;  3: return 1036; 4: return 1116;
      5: return 1290; 6: return 1372; 7: return 1410; 8: return 1480;
      9: return 1542; 10: return 1622; 11: return 1668; 12: return 139;
      13: return 347; 14: return 533; 15: return 615; default: return 2047;
    endcase
  endfunction

  function automatic int exp_code(input int i);
    if (i == 0) return 0;
    if (i <= 7) return i;
    if (i <= 11) return i - 7;
    return i - 11;
  endfunction

  function automatic int exp_high(input int i);
    return (i >= 8 && i <= 11) ? 1 : 0;
  endfunction

  function automatic int exp_entry(input int a);
    int q;
    q = (a % 128) / 4;
    if (q % 8 == 7) return 0;
    return ((3 * q) % 11) + 1;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_toggle();
    logic s;
    s = spk_out;
    @(negedge clk);
    while (spk_out == s) @(negedge clk);
  endtask

  task automatic measure_half(output int n);
    logic s;
    wait_toggle();
    s = spk_out;
    n = 0;
    while (spk_out == s) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic count_toggles(input int cycles, output int n);
    logic s;
    n = 0;
    s = spk_out;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (spk_out != s) n++;
      s = spk_out;
    end
  endtask

  task automatic send_beat();
    @(negedge clk) beat_in = 1'b1;
    wait_cyc(6);
    beat_in = 1'b0;
    wait_cyc(6);
    if (play) beats_taken++;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; beat_in = 1'b0; play = 1'b0; manual = 1'b0; keys = '0;
    beats_taken = 0;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(4);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 spk", int'(spk_out), 0);
    check("R1 code", int'(note_code), 0);
    check("R1 high", int'(note_high), 0);
  endtask

  task automatic t_keys();
    int n;
    do_reset();
    manual = 1'b1;
    for (int k = 0; k < 8; k += 7) begin
      keys = 8'(1 << k);
      wait_cyc(2100);
      check("R9 R5 key code", int'(note_code), exp_code(k + 1));
      check("R5 key high", int'(note_high), exp_high(k + 1));
      measure_half(n);
      check("R3 key half period", n, 2048 - exp_preset(k + 1));
    end
    keys = 8'b1010_0000;
    wait_cyc(3);
    check("R9 lowest key wins", int'(note_code), exp_code(6));
    keys = '0;
    wait_cyc(2100);
    check("R9 no key rest code", int'(note_code), 0);
    count_toggles(3000, n);
    check("R4 rest silent", n, 0);
  endtask

  task automatic t_score();
    int n;
    do_reset();
    play = 1'b1;
    wait_cyc(2100);
    check("R7 entry 0 code", int'(note_code), exp_code(exp_entry(0)));
    measure_half(n);
    check("R3 score half period", n, 2048 - exp_preset(exp_entry(0)));
    for (int b = 0; b < 10; b++) begin
      send_beat();
      check("R6 R7 score code", int'(note_code), exp_code(exp_entry(beats_taken)));
      check("R5 score high", int'(note_high), exp_high(exp_entry(beats_taken)));
    end
  endtask

  task automatic t_pause();
    int n;
    do_reset();
    play = 1'b1;
    repeat (3) send_beat();
    play = 1'b0;
    wait_cyc(3);
    check("R8 paused code", int'(note_code), 0);
    repeat (4) send_beat();
    wait_cyc(2100);
    count_toggles(3000, n);
    check("R8 paused silent", n, 0);
    play = 1'b1;
    wait_cyc(3);
    check("R8 resume held addr", int'(note_code), exp_code(exp_entry(3)));
  endtask

  task automatic t_coincide(input bool_late);
    do_reset();
    play = 1'b1;
    repeat (3) send_beat();
    @(negedge clk) beat_in = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    if (bool_late) @(negedge clk);
    play = 1'b0;
    wait_cyc(6);
    beat_in = 1'b0;
    wait_cyc(6);
    play = 1'b1;
    wait_cyc(3);
    if (bool_late)
      check("R10 late pause keeps step", int'(note_code), exp_code(exp_entry(4)));
    else
      check("R10 same-cycle beat dropped", int'(note_code), exp_code(exp_entry(3)));
  endtask

  task automatic t_wrap();
    do_reset();
    play = 1'b1;
    repeat (127) send_beat();
    check("R6 addr 127 entry", int'(note_code), exp_code(exp_entry(127)));
    send_beat();
    check("R6 wrap to 0", int'(note_code), exp_code(exp_entry(0)));
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_keys();
        t_score();
        t_pause();
        t_coincide(1'b0);
        t_coincide(1'b1);
        t_wrap();
      end
      begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule